// File: doc/BRIEF.md
# Depth Frame Timing Sequencer

This block is the global controller that orders the phases of every depth frame for a pixel array of time-to-digital converters. After power-on it holds the array idle until the on-chip clock generator reports a stable lock. Each frame then runs through a fixed phase order: the pixels are held in reset, a START strobe opens a collection window for photon stop events, a single LOAD strobe makes every pixel latch its code, and finally a readout trigger hands the array to the row/column readout engine. The sequencer stays in readout until that engine reports completion.

The block also regenerates the frame period. A frame counter runs from the first reset cycle, and the next frame does not begin before the programmed period has elapsed. If readout takes longer than the period, the next frame starts on the cycle right after readout completes. With a 400 MHz system clock, a 12,000-cycle period gives a 30 µs frame, which is a 33.3 kHz frame rate. A 16 × 16 readout takes 8,192 cycles (20.48 µs). A reset length of 400 and a window of 3,407 then fill the period exactly. If lock is lost at any point, the current frame is abandoned and the sequencer goes back to waiting for lock.

All phase lengths and the period come in as cycle counts on configuration inputs. The lock indication is synchronised and must be held for a parameterised number of cycles before it counts as locked.

Top module: `frame_seq_top`

## Requirements
- R1: After lock rises, the first pix_reset_o rise comes on exactly the (LOCK_HOLD+3)-th rising clock edge after the lock input is first sampled high. No strobe is asserted before it.
- R2: When lock drops, all four strobes are low from the 4th rising edge after it drops onward. The frame in progress is abandoned (no LOAD, no readout trigger), and a new frame needs lock to be qualified again as in R1.
- R3: Each frame opens with pix_reset_o high for exactly max(cfg_rst_len,1) consecutive cycles.
- R4: pix_start_o is a one-cycle pulse in the first cycle after pix_reset_o falls.
- R5: pix_load_o rises exactly max(cfg_win_len,1) cycles after pix_start_o rises. The window includes the START cycle.
- R6: pix_load_o lasts one cycle, and rd_go_o is a one-cycle pulse in the cycle right after it.
- R7: The sequencer stays in readout until rd_done_i is sampled high there. rd_done_i is ignored in every other phase.
- R8: The time from one frame's first reset cycle to the next frame's first reset cycle is max(cfg_frame_len, Rn). Here Rn = max(cfg_rst_len,1) + max(cfg_win_len,1) + 1 + (readout cycles, counting the cycle in which rd_done_i is sampled).
- R9: At most one of pix_reset_o, pix_start_o, pix_load_o and rd_go_o is high in any cycle.
- R10: While rst is high, and in the cycle after it is released, all strobes are low, whatever the lock input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_locked_i | input | 1 | Lock indication from the clock generator (asynchronous) |
| rd_done_i | input | 1 | Readout engine reports the array has been read |
| cfg_rst_len | input | CNT_W | Reset phase length in cycles (0 acts as 1) |
| cfg_win_len | input | CNT_W | Measurement window length in cycles, START included (0 acts as 1) |
| cfg_frame_len | input | CNT_W | Minimum frame period in cycles |
| pix_reset_o | output | 1 | Pixel reset level |
| pix_start_o | output | 1 | START strobe to all pixel converters |
| pix_load_o | output | 1 | LOAD strobe: pixels latch their codes |
| rd_go_o | output | 1 | Trigger for the row/column readout engine |

## Verification
Every strobe is decoded from the registered phase, so a wrong phase or a miscounted timer shows at the ports within the same frame. A wrong reset length, a missing START, a shifted LOAD or an early readout trigger each shift a strobe edge by a measurable number of cycles. A stale or stuck frame counter shows at the next frame boundary as a wrong period, either when the period dominates or when readout overruns it. A lock qualifier that leaks partial state shows in the first reset edge after lock comes back, which arrives at the wrong cycle, and in strobes that are still active four cycles after lock loss.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [2:0] {
    PH_WAIT  = 3'd0,
    PH_RESET = 3'd1,
    PH_MEAS  = 3'd2,
    PH_LOAD  = 3'd3,
    PH_READ  = 3'd4,
    PH_IDLE  = 3'd5
  } phase_t;
endpackage

// File: rtl/fseq_lock_qual.sv
module fseq_lock_qual #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_i,
  output logic qual_o
);
  localparam int CW = $clog2(HOLD + 1) + 1;

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      cnt    <= '0;
      qual_o <= 1'b0;
    end else begin
      s1 <= lock_i;
      s2 <= s1;
      if (!s2) begin
        cnt    <= '0;
        qual_o <= 1'b0;
      end else begin
        if (cnt != CW'(HOLD)) cnt <= cnt + 1'b1;
        qual_o <= (cnt >= CW'(HOLD - 1));
      end
    end
  end
endmodule

// File: rtl/fseq_phase_timer.sv
module fseq_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);
  logic [W-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst)              tcnt <= '0;
    else if (load_i)      tcnt <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (tcnt != '0)  tcnt <= tcnt - 1'b1;
  end

  assign expire_o = (tcnt == '0);
endmodule

// File: rtl/fseq_frame_timer.sv
module fseq_frame_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [W-1:0] len_i,
  output logic         due_o
);
  logic [W-1:0] fcnt;
  logic [W:0]   elapsed;

  always_ff @(posedge clk) begin
    if (rst || clr_i)    fcnt <= '0;
    else if (fcnt != '1) fcnt <= fcnt + 1'b1;
  end

  assign elapsed = {1'b0, fcnt} + (W+1)'(1);
  assign due_o   = (elapsed >= {1'b0, len_i});
endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
  import frame_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int LOCK_HOLD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pll_locked_i,
  input  logic             rd_done_i,
  input  logic [CNT_W-1:0] cfg_rst_len,
  input  logic [CNT_W-1:0] cfg_win_len,
  input  logic [CNT_W-1:0] cfg_frame_len,
  output logic             pix_reset_o,
  output logic             pix_start_o,
  output logic             pix_load_o,
  output logic             rd_go_o
);
  phase_t             st, nx;
  logic               locked;
  logic               expire;
  logic               due;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_len;
  logic               frame_clr;

  fseq_lock_qual #(.HOLD(LOCK_HOLD)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .lock_i (pll_locked_i),
    .qual_o (locked)
  );

  fseq_phase_timer #(.W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (expire)
  );

  fseq_frame_timer #(.W(CNT_W)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .clr_i (frame_clr),
    .len_i (cfg_frame_len),
    .due_o (due)
  );

  always_comb begin
    nx = st;
    case (st)
      PH_WAIT:  if (locked) nx = PH_RESET;
      PH_RESET: if (expire) nx = PH_MEAS;
      PH_MEAS:  if (expire) nx = PH_LOAD;
      PH_LOAD:  nx = PH_READ;
      PH_READ:  if (rd_done_i) nx = due ? PH_RESET : PH_IDLE;
      PH_IDLE:  if (due) nx = PH_RESET;
      default:  nx = PH_WAIT;
    endcase
    if (!locked) nx = PH_WAIT;
  end

  always_comb begin
    tmr_load  = 1'b0;
    tmr_len   = cfg_rst_len;
    frame_clr = (st == PH_WAIT);
    if (nx == PH_RESET && st != PH_RESET) begin
      tmr_load  = 1'b1;
      tmr_len   = cfg_rst_len;
      frame_clr = 1'b1;
    end else if (nx == PH_MEAS && st != PH_MEAS) begin
      tmr_load  = 1'b1;
      tmr_len   = cfg_win_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= PH_WAIT;
      pix_reset_o <= 1'b0;
      pix_start_o <= 1'b0;
      pix_load_o  <= 1'b0;
      rd_go_o     <= 1'b0;
    end else begin
      st          <= nx;
      pix_reset_o <= (nx == PH_RESET);
      pix_start_o <= (nx == PH_MEAS) && (st != PH_MEAS);
      pix_load_o  <= (nx == PH_LOAD);
      rd_go_o     <= (nx == PH_READ) && (st != PH_READ);
    end
  end
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
  input logic clk,
  input logic rst,
  input logic pll_locked_i,
  input logic pix_reset_o,
  input logic pix_start_o,
  input logic pix_load_o,
  input logic rd_go_o
);
  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pix_reset_o, pix_start_o, pix_load_o, rd_go_o}));

  // R4
  start_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    pix_start_o |-> $past(pix_reset_o));

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    pix_start_o |=> !pix_start_o);

  // R6
  load_then_go_chk: assert property (@(posedge clk) disable iff (rst)
    pix_load_o |=> (rd_go_o && !pix_load_o));

  // R6
  go_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go_o |-> $past(pix_load_o));

  // R2
  lock_loss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!pll_locked_i && !$past(pll_locked_i, 1) && !$past(pll_locked_i, 2) &&
     !$past(pll_locked_i, 3) && !$past(pll_locked_i, 4))
    |-> !(pix_reset_o || pix_start_o || pix_load_o || rd_go_o));

  // R1
  reset_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_reset_o) |-> ($past(pll_locked_i, 1) && $past(pll_locked_i, 2) &&
                            $past(pll_locked_i, 3)));
endmodule

bind frame_seq_top fseq_chk u_fseq_chk (
  .clk          (clk),
  .rst          (rst),
  .pll_locked_i (pll_locked_i),
  .pix_reset_o  (pix_reset_o),
  .pix_start_o  (pix_start_o),
  .pix_load_o   (pix_load_o),
  .rd_go_o      (rd_go_o)
);

// File: tb/frame_seq_top_test.sv
module frame_seq_top_test;
  localparam int CNT_W     = 16;
  localparam int LOCK_HOLD = 4;
  localparam int GUARD     = 100000;

  logic clk = 1'b0;
  logic rst;
  logic pll_locked_i;
  logic rd_done_i;
  logic [CNT_W-1:0] cfg_rst_len, cfg_win_len, cfg_frame_len;
  logic pix_reset_o, pix_start_o, pix_load_o, rd_go_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  frame_seq_top #(.CNT_W(CNT_W), .LOCK_HOLD(LOCK_HOLD)) uut (
    .clk(clk), .rst(rst), .pll_locked_i(pll_locked_i), .rd_done_i(rd_done_i),
    .cfg_rst_len(cfg_rst_len), .cfg_win_len(cfg_win_len),
    .cfg_frame_len(cfg_frame_len), .pix_reset_o(pix_reset_o),
    .pix_start_o(pix_start_o), .pix_load_o(pix_load_o), .rd_go_o(rd_go_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int at_least1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int exp_period(input int r, input int w, input int l, input int d);
    int nat;
    nat = at_least1(r) + at_least1(w) + 1 + d + 1;
    return (l > nat) ? l : nat;
  endfunction

  function automatic int strobes();
    return int'({pix_reset_o, pix_start_o, pix_load_o, rd_go_o});
  endfunction

  // drop lock, program, raise lock; returns at the first reset cycle
  task automatic lock_up(input int r, input int w, input int l);
    int n;
    bit early;
    pll_locked_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(strobes() == 0, "R2 quiet while unlocked", strobes(), 0);
    cfg_rst_len   = CNT_W'(r);
    cfg_win_len   = CNT_W'(w);
    cfg_frame_len = CNT_W'(l);
    pll_locked_i  = 1'b1;
    n = 0;
    early = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (pix_start_o || pix_load_o || rd_go_o) early = 1'b1;
    end while (!pix_reset_o && n < 200);
    chk(n == LOCK_HOLD + 3, "R1 lock-to-reset edges", n, LOCK_HOLD + 3);
    chk(!early, "R1 no strobe before first reset", int'(early), 0);
  endtask

  // called at the negedge of a frame's first reset cycle
  task automatic frame(input int r, input int w, input int l, input int d, input bit spur);
    int t0, n, per;
    t0 = cyc;
    n = 0;
    while (pix_reset_o && n < GUARD) begin n++; @(negedge clk); end
    chk(n == at_least1(r), "R3 reset width", n, at_least1(r));
    chk(pix_start_o == 1'b1, "R4 start after reset", int'(pix_start_o), 1);
    n = 0;
    while (!pix_load_o && n < GUARD) begin
      if (spur && n == 0) rd_done_i = 1'b1;
      n++;
      @(negedge clk);
      rd_done_i = 1'b0;
      if (n == 1) chk(pix_start_o == 1'b0 || pix_load_o, "R4 start single", int'(pix_start_o), 0);
    end
    chk(n == at_least1(w), spur ? "R7 R5 window with stray done" : "R5 window length",
        n, at_least1(w));
    @(negedge clk);
    chk(!pix_load_o && rd_go_o, "R6 load then rd_go", strobes(), 1);
    repeat (d) @(negedge clk);
    chk(!pix_reset_o, "R7 waits in readout", int'(pix_reset_o), 0);
    rd_done_i = 1'b1;
    @(negedge clk);
    rd_done_i = 1'b0;
    n = 0;
    while (!pix_reset_o && n < GUARD) begin n++; @(negedge clk); end
    per = cyc - t0;
    chk(per == exp_period(r, w, l, d), spur ? "R8 R7 frame period" : "R8 frame period",
        per, exp_period(r, w, l, d));
  endtask

  always @(posedge clk) begin
    if (cyc > 190000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst = 1'b1;
    pll_locked_i = 1'b1;
    rd_done_i = 1'b0;
    cfg_rst_len = '0;
    cfg_win_len = '0;
    cfg_frame_len = '0;
    repeat (5) begin
      @(negedge clk);
      chk(strobes() == 0, "R10 strobes low in reset", strobes(), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(strobes() == 0, "R10 strobes low after reset", strobes(), 0);

    // full-size frame: 400 + 3407 + 1 + 8192 = 12000 cycles
    lock_up(400, 3407, 12000);
    frame(400, 3407, 12000, 8191, 1'b0);
    frame(400, 3407, 12000, 8191, 1'b1);

    // zero lengths and zero period
    lock_up(0, 0, 0);
    frame(0, 0, 0, 0, 1'b0);
    frame(0, 0, 0, 0, 1'b1);

    // readout overruns the period
    lock_up(5, 7, 10);
    frame(5, 7, 10, 20, 1'b0);

    // period dominates
    lock_up(3, 4, 150);
    frame(3, 4, 150, 2, 1'b1);

    // abort mid-window
    lock_up(10, 30, 200);
    repeat (15) @(negedge clk);
    pll_locked_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(strobes() == 0, "R2 strobes low 4 edges after lock loss", strobes(), 0);
    begin
      bit seen;
      seen = 1'b0;
      repeat (60) begin
        @(negedge clk);
        if (strobes() != 0) seen = 1'b1;
      end
      chk(!seen, "R2 frame abandoned", int'(seen), 0);
    end

    // random scenarios
    for (int s = 0; s < 25; s++) begin
      int r, w, l;
      r = int'($urandom % 40);
      w = int'($urandom % 40);
      l = int'($urandom % 160);
      lock_up(r, w, l);
      for (int f = 0; f < 3; f++) begin
        frame(r, w, l, int'($urandom % 30), bit'($urandom % 2));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule